// File: doc/BRIEF.md
# Transmit Start and Short-Frame Padding Controller

This block sits between a host interface and a CSMA/CD MAC and decides when an outgoing frame may start and how a short frame is stretched. The host writes a command word, writes the frame length, and then reads the status. The bid is judged at that status read. A length outside the legal range is refused with an error flag. A legal length waits until the buffer reports enough free space, and the block then raises a ready flag. The host polls this flag before it loads frame data.

While the host loads bytes, the block counts them. When the count reaches the chosen start point, it pulses a start strobe to the MAC. The start point is 5, 381 or 1021 bytes, or the whole frame. From then on the MAC takes one byte per cycle. The block gives it the byte position and the data, with zero bytes appended to a short frame when padding is on. It also tells the MAC whether to append a CRC. If the MAC asks for a byte that the host has not written yet, the block stops the frame and raises an underrun flag.

Top module: `tx_bid_pad`

## Requirements
- R1: After reset, rdy_now, bid_err, tx_underrun, mac_start and rdy_irq are all 0.
- R2: cmd_thresh selects the start point: 0 is 5 bytes, 1 is 381, 2 is 1021 and 3 is the full length. The effective start point is the smaller of that value and the frame length. mac_start is high for exactly one cycle, in the cycle after the host write that brings the count to the start point.
- R3: A bid follows the order cmd_wr, then len_wr, then stat_rd. A stat_rd that arrives before a length has been written has no effect.
- R4: At the status read, a legal bid sets rdy_now only if buf_free is at least the length. Otherwise the bid is deferred, and rdy_now rises in the cycle after buf_free first reaches the length.
- R5: When a deferred bid becomes ready and cmd_rdy_ie was 1 in its command, rdy_irq is high for one cycle, together with the rise of rdy_now. With cmd_rdy_ie at 0, rdy_irq stays 0.
- R6: With cmd_pad_off at 0, a frame shorter than 60 bytes is sent as 60 bytes. The extra bytes come out with tx_pad at 1 and tx_data at 8'h00. This holds whatever the CRC option is.
- R7: With cmd_pad_off at 1, the frame is sent with exactly the requested length.
- R8: During sending, crc_append equals the inverse of cmd_crc_off.
- R9: A length below 3, or above BUF_BYTES, sets bid_err at the status read. No space is committed, rdy_now stays 0, and host writes start nothing.
- R10: If the MAC asks for a frame byte (mac_take) at a position the host has not yet written, tx_valid is 0. tx_underrun is then set and rdy_now falls.
- R11: An accepted cmd_wr clears bid_err, tx_underrun and the byte count. A cmd_wr while a frame is being sent is ignored.
- R12: Each byte taken carries its position on tx_pos, counting from 0. For positions below the length, tx_data equals buf_data. tx_last marks the final byte, after which rdy_now falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_thresh | input | 2 | Start point code |
| cmd_pad_off | input | 1 | 1 disables short-frame padding |
| cmd_crc_off | input | 1 | 1 inhibits CRC append |
| cmd_rdy_ie | input | 1 | Interrupt enable for deferred readiness |
| len_wr | input | 1 | Length write strobe |
| len_val | input | LEN_W | Requested frame length in bytes |
| stat_rd | input | 1 | Status read strobe that evaluates the bid |
| buf_free | input | LEN_W | Free buffer bytes available for the bid |
| host_wr | input | 1 | Host wrote one frame byte |
| mac_take | input | 1 | MAC takes one byte this cycle |
| buf_data | input | 8 | Buffer byte at tx_pos |
| rdy_now | output | 1 | Space committed, host may load data |
| bid_err | output | 1 | Illegal length was bid |
| rdy_irq | output | 1 | One-cycle interrupt on deferred ready |
| mac_start | output | 1 | One-cycle start strobe to MAC |
| crc_append | output | 1 | MAC should append CRC |
| tx_valid | output | 1 | Byte delivered to MAC this cycle |
| tx_pad | output | 1 | Delivered byte is padding |
| tx_last | output | 1 | Current position is the final byte |
| tx_pos | output | LEN_W | Current byte position |
| tx_data | output | 8 | Byte to the MAC |
| tx_underrun | output | 1 | Host fell behind the MAC |

## Verification
The hardest conditions to reach are the 381-byte and 1021-byte start points and the window in which the MAC has overtaken the host. To reach the first two, the bench writes long frames one byte per cycle and checks the strobe after every single write. To reach the underrun, it loads only part of a frame past the start point and then lets the MAC pull on every cycle, so the MAC passes the last written byte. Deferred readiness is reached by holding buf_free below the bid length across the status read and raising it later.

// File: rtl/tx_bid_pad_pkg.sv
package tx_bid_pad_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_LEN,
        ST_WAIT,
        ST_READY,
        ST_SEND
    } bid_state_e;

    typedef enum logic [1:0] {
        TH_EARLY = 2'd0,
        TH_MID   = 2'd1,
        TH_LATE  = 2'd2,
        TH_FULL  = 2'd3
    } thresh_e;

    typedef struct packed {
        thresh_e thresh;
        logic    pad_off;
        logic    crc_off;
        logic    rdy_ie;
    } tx_cmd_t;

    localparam int unsigned START_EARLY = 5;
    localparam int unsigned START_MID   = 381;
    localparam int unsigned START_LATE  = 1021;
    localparam int unsigned MIN_LEN     = 3;
    localparam int unsigned PAD_TARGET  = 60;

    // Effective start point: threshold capped at the frame length
    function automatic int unsigned start_point(thresh_e t, int unsigned len);
        int unsigned lim;
        case (t)
            TH_EARLY: lim = START_EARLY;
            TH_MID:   lim = START_MID;
            TH_LATE:  lim = START_LATE;
            default:  lim = len;
        endcase
        return (lim < len) ? lim : len;
    endfunction

endpackage

// File: rtl/tx_bid_ctrl.sv
module tx_bid_ctrl
    import tx_bid_pad_pkg::*;
#(
    parameter int LEN_W     = 11,
    parameter int BUF_BYTES = 1536
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr,
    input  tx_cmd_t          cmd_in,
    input  logic             len_wr,
    input  logic [LEN_W-1:0] len_val,
    input  logic             stat_rd,
    input  logic [LEN_W-1:0] buf_free,
    input  logic             start_hit,
    input  logic             frame_end,
    input  logic             starve_hit,
    output bid_state_e       state,
    output tx_cmd_t          cmd_q,
    output logic [LEN_W-1:0] len_q,
    output logic             cmd_acc,
    output logic             bid_err,
    output logic             underrun,
    output logic             rdy_irq
);

    localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(BUF_BYTES);

    logic len_bad;
    logic space_ok;

    assign cmd_acc  = cmd_wr && (state != ST_SEND);
    assign len_bad  = (len_q < LEN_MIN) || (len_q > LEN_MAX);
    assign space_ok = (buf_free >= len_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cmd_q    <= '0;
            len_q    <= '0;
            bid_err  <= 1'b0;
            underrun <= 1'b0;
            rdy_irq  <= 1'b0;
        end else begin
            rdy_irq <= 1'b0;
            if (cmd_acc) begin
                state    <= ST_CMD;
                cmd_q    <= cmd_in;
                bid_err  <= 1'b0;
                underrun <= 1'b0;
            end else begin
                case (state)
                    ST_CMD: begin
                        if (len_wr) begin
                            len_q <= len_val;
                            state <= ST_LEN;
                        end
                    end
                    ST_LEN: begin
                        if (stat_rd) begin
                            if (len_bad) begin
                                bid_err <= 1'b1;
                                state   <= ST_IDLE;
                            end else if (space_ok) begin
                                state <= ST_READY;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end
                    end
                    ST_WAIT: begin
                        if (space_ok) begin
                            state   <= ST_READY;
                            rdy_irq <= cmd_q.rdy_ie;
                        end
                    end
                    ST_READY: begin
                        if (start_hit) state <= ST_SEND;
                    end
                    ST_SEND: begin
                        if (starve_hit) begin
                            underrun <= 1'b1;
                            state    <= ST_IDLE;
                        end else if (frame_end) begin
                            state <= ST_IDLE;
                        end
                    end
                    default: state <= state;
                endcase
            end
        end
    end

endmodule

// File: rtl/tx_frame_seq.sv
module tx_frame_seq
    import tx_bid_pad_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  bid_state_e       state,
    input  thresh_e          thresh,
    input  logic             pad_off,
    input  logic [LEN_W-1:0] len_q,
    input  logic             clear,
    input  logic             host_wr,
    input  logic             mac_take,
    input  logic [7:0]       buf_data,
    output logic             start_hit,
    output logic             mac_start,
    output logic             frame_end,
    output logic             starve_hit,
    output logic             tx_valid,
    output logic             tx_pad,
    output logic             tx_last,
    output logic [LEN_W-1:0] tx_pos,
    output logic [7:0]       tx_data
);

    localparam logic [LEN_W-1:0] PAD_LEN = LEN_W'(PAD_TARGET);
    localparam logic [LEN_W-1:0] ONE     = LEN_W'(1);

    logic [LEN_W-1:0] wr_cnt;
    logic [LEN_W-1:0] tx_cnt;
    logic [LEN_W-1:0] thr;
    logic [LEN_W-1:0] frame_len;
    logic             in_send;
    logic             wr_take;
    logic             starve;

    assign thr       = LEN_W'(start_point(thresh, 32'(len_q)));
    assign frame_len = (!pad_off && (len_q < PAD_LEN)) ? PAD_LEN : len_q;
    assign in_send   = (state == ST_SEND);
    assign wr_take   = host_wr && ((state == ST_READY) || in_send) && (wr_cnt < len_q);
    assign start_hit = (state == ST_READY) && wr_take && ((wr_cnt + ONE) == thr);

    // A frame byte is available from the cycle after its host write
    assign starve     = (tx_cnt < len_q) && (tx_cnt >= wr_cnt);
    assign tx_valid   = in_send && mac_take && !starve;
    assign starve_hit = in_send && mac_take && starve;
    assign tx_pad     = (tx_cnt >= len_q);
    assign tx_last    = (tx_cnt == (frame_len - ONE));
    assign tx_pos     = tx_cnt;
    assign tx_data    = tx_pad ? 8'h00 : buf_data;
    assign frame_end  = tx_valid && tx_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_cnt    <= '0;
            tx_cnt    <= '0;
            mac_start <= 1'b0;
        end else begin
            mac_start <= start_hit;
            if (clear) begin
                wr_cnt <= '0;
                tx_cnt <= '0;
            end else begin
                if (wr_take)  wr_cnt <= wr_cnt + ONE;
                if (tx_valid) tx_cnt <= tx_cnt + ONE;
            end
        end
    end

endmodule

// File: rtl/tx_bid_pad.sv
module tx_bid_pad
    import tx_bid_pad_pkg::*;
#(
    parameter int LEN_W     = 11,
    parameter int BUF_BYTES = 1536
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr,
    input  logic [1:0]       cmd_thresh,
    input  logic             cmd_pad_off,
    input  logic             cmd_crc_off,
    input  logic             cmd_rdy_ie,
    input  logic             len_wr,
    input  logic [LEN_W-1:0] len_val,
    input  logic             stat_rd,
    input  logic [LEN_W-1:0] buf_free,
    input  logic             host_wr,
    input  logic             mac_take,
    input  logic [7:0]       buf_data,
    output logic             rdy_now,
    output logic             bid_err,
    output logic             rdy_irq,
    output logic             mac_start,
    output logic             crc_append,
    output logic             tx_valid,
    output logic             tx_pad,
    output logic             tx_last,
    output logic [LEN_W-1:0] tx_pos,
    output logic [7:0]       tx_data,
    output logic             tx_underrun
);

    tx_cmd_t          cmd_in;
    tx_cmd_t          cmd_q;
    bid_state_e       state;
    logic [LEN_W-1:0] len_q;
    logic             cmd_acc;
    logic             start_hit;
    logic             frame_end;
    logic             starve_hit;

    assign cmd_in = '{thresh: thresh_e'(cmd_thresh), pad_off: cmd_pad_off,
                      crc_off: cmd_crc_off, rdy_ie: cmd_rdy_ie};

    tx_bid_ctrl #(.LEN_W(LEN_W), .BUF_BYTES(BUF_BYTES)) u_ctrl (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_in(cmd_in),
        .len_wr(len_wr), .len_val(len_val), .stat_rd(stat_rd),
        .buf_free(buf_free), .start_hit(start_hit), .frame_end(frame_end),
        .starve_hit(starve_hit), .state(state), .cmd_q(cmd_q), .len_q(len_q),
        .cmd_acc(cmd_acc), .bid_err(bid_err), .underrun(tx_underrun),
        .rdy_irq(rdy_irq)
    );

    tx_frame_seq #(.LEN_W(LEN_W)) u_seq (
        .clk(clk), .rst(rst), .state(state), .thresh(cmd_q.thresh),
        .pad_off(cmd_q.pad_off), .len_q(len_q), .clear(cmd_acc),
        .host_wr(host_wr), .mac_take(mac_take), .buf_data(buf_data),
        .start_hit(start_hit), .mac_start(mac_start), .frame_end(frame_end),
        .starve_hit(starve_hit), .tx_valid(tx_valid), .tx_pad(tx_pad),
        .tx_last(tx_last), .tx_pos(tx_pos), .tx_data(tx_data)
    );

    assign rdy_now    = (state == ST_READY) || (state == ST_SEND);
    assign crc_append = (state == ST_SEND) && !cmd_q.crc_off;

endmodule

// File: rtl/tx_bid_pad_chk.sv
module tx_bid_pad_chk (
    input logic       clk,
    input logic       rst,
    input logic       rdy_now,
    input logic       bid_err,
    input logic       rdy_irq,
    input logic       mac_start,
    input logic       crc_append,
    input logic       tx_valid,
    input logic       tx_pad,
    input logic [7:0] tx_data,
    input logic       tx_underrun,
    input logic       mac_take
);

    p_start_ready_r2: assert property (@(posedge clk) disable iff (rst)
        mac_start |-> rdy_now);

    p_start_single_r2: assert property (@(posedge clk) disable iff (rst)
        mac_start |=> !mac_start);

    p_irq_rise_r5: assert property (@(posedge clk) disable iff (rst)
        rdy_irq |-> $rose(rdy_now));

    p_pad_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_pad) |-> (tx_data == 8'h00));

    p_crc_in_send_r8: assert property (@(posedge clk) disable iff (rst)
        crc_append |-> rdy_now);

    p_err_no_ready_r9: assert property (@(posedge clk) disable iff (rst)
        bid_err |-> !rdy_now);

    p_underrun_stop_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_underrun) |-> (!rdy_now && $past(rdy_now)));

    p_valid_taken_r12: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (mac_take && rdy_now));

endmodule

bind tx_bid_pad tx_bid_pad_chk u_chk (
    .clk(clk), .rst(rst), .rdy_now(rdy_now), .bid_err(bid_err),
    .rdy_irq(rdy_irq), .mac_start(mac_start), .crc_append(crc_append),
    .tx_valid(tx_valid), .tx_pad(tx_pad), .tx_data(tx_data),
    .tx_underrun(tx_underrun), .mac_take(mac_take)
);

// File: tb/tx_bid_pad_test.sv
module tx_bid_pad_test;

    localparam int LEN_W = 11;
    localparam int BUF_BYTES = 1536;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cmd_wr = 1'b0;
    logic [1:0]       cmd_thresh = 2'd0;
    logic             cmd_pad_off = 1'b0;
    logic             cmd_crc_off = 1'b0;
    logic             cmd_rdy_ie = 1'b0;
    logic             len_wr = 1'b0;
    logic [LEN_W-1:0] len_val = '0;
    logic             stat_rd = 1'b0;
    logic [LEN_W-1:0] buf_free = LEN_W'(BUF_BYTES);
    logic             host_wr = 1'b0;
    logic             mac_take = 1'b0;
    logic [7:0]       buf_data;
    logic             rdy_now, bid_err, rdy_irq, mac_start, crc_append;
    logic             tx_valid, tx_pad, tx_last, tx_underrun;
    logic [LEN_W-1:0] tx_pos;
    logic [7:0]       tx_data;

    int n_chk = 0;
    int n_fail = 0;

    always #5ns clk = ~clk;

    assign buf_data = tx_pos[7:0] ^ 8'h5A;

    tx_bid_pad #(.LEN_W(LEN_W), .BUF_BYTES(BUF_BYTES)) uut (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_thresh(cmd_thresh),
        .cmd_pad_off(cmd_pad_off), .cmd_crc_off(cmd_crc_off),
        .cmd_rdy_ie(cmd_rdy_ie), .len_wr(len_wr), .len_val(len_val),
        .stat_rd(stat_rd), .buf_free(buf_free), .host_wr(host_wr),
        .mac_take(mac_take), .buf_data(buf_data), .rdy_now(rdy_now),
        .bid_err(bid_err), .rdy_irq(rdy_irq), .mac_start(mac_start),
        .crc_append(crc_append), .tx_valid(tx_valid), .tx_pad(tx_pad),
        .tx_last(tx_last), .tx_pos(tx_pos), .tx_data(tx_data),
        .tx_underrun(tx_underrun)
    );

    function automatic int exp_frame(int len, bit pad_off);
        return (!pad_off && len < 60) ? 60 : len;
    endfunction

    function automatic int exp_start(int code, int len);
        int lim;
        case (code)
            0: lim = 5;
            1: lim = 381;
            2: lim = 1021;
            default: lim = len;
        endcase
        return (lim < len) ? lim : len;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_cmd(input int code, input bit po, input bit co, input bit ie);
        @(negedge clk);
        cmd_thresh = 2'(code); cmd_pad_off = po; cmd_crc_off = co; cmd_rdy_ie = ie;
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic do_len(input int len);
        @(negedge clk);
        len_val = LEN_W'(len); len_wr = 1'b1;
        @(negedge clk);
        len_wr = 1'b0;
    endtask

    task automatic do_stat();
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic bid(input int code, input bit po, input bit co, input bit ie, input int len);
        do_cmd(code, po, co, ie);
        do_len(len);
        do_stat();
    endtask

    // Write n bytes back to back; strobe must appear only after write number start_at
    task automatic write_n(input int n, input int start_at, input string req);
        int seen = 0;
        int bad = 0;
        for (int i = 1; i <= n; i++) begin
            host_wr = 1'b1;
            @(negedge clk);
            host_wr = 1'b0;
            if (mac_start) begin
                seen++;
                if (i != start_at) bad++;
            end
        end
        check({req, " start strobe count"}, seen, (start_at > 0) ? 1 : 0);
        check({req, " start strobe position"}, bad, 0);
    endtask

    task automatic drain(input int len, input bit po, input bit crc, input string req);
        int got = 0;
        int bad = 0;
        int crcbad = 0;
        bit done = 0;
        mac_take = 1'b1;
        for (int k = 0; k < 3000 && !done; k++) begin
            #1;
            if (tx_valid) begin
                if (tx_pos != LEN_W'(got)) bad++;
                if (got >= len) begin
                    if (!tx_pad || tx_data != 8'h00) bad++;
                end else begin
                    if (tx_pad || tx_data != (8'(got) ^ 8'h5A)) bad++;
                end
                if (crc_append != crc) crcbad++;
                got++;
                if (tx_last) done = 1;
            end
            @(negedge clk);
        end
        mac_take = 1'b0;
        check({req, " frame bytes"}, got, exp_frame(len, po));
        check({req, " R12 byte content"}, bad, 0);
        check({req, " R8 crc_append"}, crcbad, 0);
        check({req, " R12 idle after last"}, int'(rdy_now), 0);
    endtask

    initial begin
        #1_500_000ns;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 rdy_now", int'(rdy_now), 0);
        check("R1 bid_err", int'(bid_err), 0);
        check("R1 tx_underrun", int'(tx_underrun), 0);
        check("R1 mac_start", int'(mac_start), 0);
        check("R1 rdy_irq", int'(rdy_irq), 0);

        // R3 ordering: status read before length has no effect
        do_stat();
        check("R3 stat in idle", int'(rdy_now), 0);
        do_cmd(0, 0, 0, 0);
        do_stat();
        check("R3 stat before len", int'(rdy_now), 0);
        do_len(10);
        check("R3 no ready before stat", int'(rdy_now), 0);
        do_stat();
        check("R4 ready after stat", int'(rdy_now), 1);
        write_n(10, 5, "R2 early");
        drain(10, 0, 1, "R6 pad with crc");

        // R2 mid and late start points
        bid(1, 1, 0, 0, 400);
        write_n(400, 381, "R2 mid");
        drain(400, 1, 1, "R2 mid frame");
        bid(2, 1, 1, 0, 1500);
        write_n(1500, 1021, "R2 late");
        drain(1500, 1, 0, "R2 late frame");
        bid(2, 1, 0, 0, 1000);
        write_n(1000, 1000, "R2 late capped");
        drain(1000, 1, 1, "R2 capped frame");
        bid(3, 0, 0, 0, 70);
        write_n(70, 70, "R2 full");
        drain(70, 0, 1, "R2 full frame");

        // R7 pad off, R6 pad on with crc inhibited
        bid(0, 1, 0, 0, 3);
        write_n(3, 3, "R7 min");
        drain(3, 1, 1, "R7 unpadded");
        bid(0, 0, 1, 0, 40);
        write_n(40, 5, "R6 crc off");
        drain(40, 0, 0, "R6 pad no crc");

        // R9 illegal lengths
        bid(0, 0, 0, 0, 2);
        check("R9 short err", int'(bid_err), 1);
        check("R9 short not ready", int'(rdy_now), 0);
        write_n(6, 0, "R9 writes ignored");
        bid(0, 0, 0, 0, BUF_BYTES + 1);
        check("R9 long err", int'(bid_err), 1);
        check("R9 long not ready", int'(rdy_now), 0);
        do_cmd(0, 0, 0, 0);
        check("R11 cmd clears err", int'(bid_err), 0);

        // R4 and R5 deferred bid with interrupt
        buf_free = LEN_W'(50);
        bid(0, 1, 0, 1, 100);
        check("R4 deferred", int'(rdy_now), 0);
        repeat (3) @(negedge clk);
        check("R4 still deferred", int'(rdy_now), 0);
        check("R5 no early irq", int'(rdy_irq), 0);
        buf_free = LEN_W'(100);
        @(negedge clk);
        check("R4 ready after space", int'(rdy_now), 1);
        check("R5 irq pulse", int'(rdy_irq), 1);
        @(negedge clk);
        check("R5 irq one cycle", int'(rdy_irq), 0);
        write_n(100, 5, "R4 deferred frame");
        drain(100, 1, 1, "R4 deferred drain");
        buf_free = LEN_W'(50);
        bid(0, 1, 0, 0, 100);
        buf_free = LEN_W'(BUF_BYTES);
        @(negedge clk);
        check("R5 irq disabled", int'(rdy_irq), 0);
        check("R5 ready w/o irq", int'(rdy_now), 1);

        // R10 underrun
        bid(0, 0, 0, 0, 20);
        write_n(5, 5, "R10 partial");
        begin
            int v = 0;
            mac_take = 1'b1;
            for (int k = 0; k < 5; k++) begin
                #1;
                if (tx_valid) v++;
                @(negedge clk);
            end
            #1;
            check("R10 written bytes delivered", v, 5);
            check("R10 starved byte invalid", int'(tx_valid), 0);
            @(negedge clk);
            mac_take = 1'b0;
        end
        check("R10 underrun flag", int'(tx_underrun), 1);
        check("R10 ready dropped", int'(rdy_now), 0);
        do_cmd(0, 0, 0, 0);
        check("R11 cmd clears underrun", int'(tx_underrun), 0);

        // R11 counter restart on new command
        do_len(50);
        do_stat();
        write_n(3, 0, "R11 before restart");
        bid(0, 0, 0, 0, 50);
        write_n(4, 0, "R11 after restart 4");
        write_n(1, 1, "R11 fifth write");
        write_n(45, 0, "R11 rest");
        drain(50, 0, 1, "R11 restarted frame");

        // R11 command ignored during sending
        bid(0, 0, 0, 0, 8);
        write_n(8, 5, "R11 send");
        do_cmd(3, 1, 1, 0);
        check("R11 send keeps ready", int'(rdy_now), 1);
        drain(8, 0, 1, "R11 cmd ignored");

        // Random frames
        for (int f = 0; f < 30; f++) begin
            int len = 3 + int'($urandom_range(0, 197));
            int code = ($urandom_range(0, 1) == 0) ? 0 : 3;
            bit po = 1'($urandom_range(0, 1));
            bit co = 1'($urandom_range(0, 1));
            bid(code, po, co, 0, len);
            write_n(len, exp_start(code, len), "R2 random");
            drain(len, po, !co, "R6 R7 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule